// File: doc/BRIEF.md
# Nibble Accumulator and Carry Execution Unit

This block is the arithmetic heart of a small 4-bit processor. It holds a 4-bit accumulator and a 1-bit carry/link flag. When an operation is presented with a valid strobe, it updates both in a single clock. The surrounding pipeline decodes the instruction and reads the register or memory operand. It then hands this unit an operation code, the operand nibble and an immediate nibble.

Accumulator and carry are registered, and they are visible at the ports. An exchange also returns the accumulator value from before the exchange, one cycle later, with a write-enable flag. The caller uses it to write that value back into the index register that was swapped.

The carry follows inverted-borrow semantics on subtract and decrement. A carry of 1 means no borrow took place.

Top module: `nibble_acc_alu`

## Requirements
- R1: With `rst` high at a clock edge, the next state is `acc_q`=0, `cy_q`=0 and `xch_we`=0.
- R2: The accumulator and carry hold their values when `op_valid` is low at an edge. They also hold when the code is undefined (0x0D..0x0F, 0x17..0x1F).
- R3: ADD (0x10) loads ACC with the low nibble of ACC+operand+CY. CY becomes 1 exactly when that sum exceeds 15.
- R4: SUB (0x11) loads ACC with the low nibble of ACC + (15−operand) + CY. CY becomes 1 when that sum exceeds 15 (no borrow), otherwise 0.
- R5: IAC (0x02) adds 1 to ACC, and CY is 1 only on the wrap from 15 to 0. DAC (0x08) adds 15 to ACC, and CY is 0 only when ACC was 0.
- R6: CLB (0x00) clears ACC and CY. CLC (0x01) clears CY. STC (0x0A) sets CY. CMC (0x03) inverts CY. CMA (0x04) inverts ACC. None of these five changes the other register.
- R7: RAL (0x05) shifts ACC left, with CY entering bit 0 and bit 3 leaving into CY. RAR (0x06) shifts ACC right, with CY entering bit 3 and bit 0 leaving into CY.
- R8: TCC (0x07) sets ACC to CY (zero-extended). TCS (0x09) sets ACC to 10 when CY=1 and to 9 when CY=0. Both clear CY.
- R9: DAA (0x0B) adds 6 to ACC when CY=1 or ACC>9, and otherwise leaves ACC unchanged. CY is set to 1 when that addition passes 15, and is otherwise left as it was.
- R10: KBP (0x0C) maps ACC as follows: 0→0, 1→1, 2→2, 4→3 and 8→4. Any value with two or more bits set maps to 15. CY is unchanged.
- R11: LD (0x12) loads the operand into ACC and LDM (0x14) loads the immediate into ACC. ORR (0x15) ORs the operand into ACC and ANR (0x16) ANDs it into ACC. All four leave CY unchanged.
- R12: XCH (0x13) loads the operand into ACC and leaves CY unchanged. At the same edge, `xch_we` rises and `xch_data` takes the old ACC. After any other edge, `xch_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 5 | Operation code |
| operand | input | 4 | Register or memory operand |
| imm | input | 4 | Immediate nibble |
| acc_q | output | 4 | Accumulator |
| cy_q | output | 1 | Carry/link flag |
| xch_we | output | 1 | Exchange write-back strobe |
| xch_data | output | 4 | Accumulator value before the exchange |

## Verification
The assertions take two things for granted about the inputs. First, `op_code` is stable and meaningful only while `op_valid` is high. Second, the pipeline never issues an operation in the cycle that `rst` is high.

The stimulus drives inputs only on the falling edge, and it lowers `op_valid` whenever the code is not meant to act. Undefined codes are sent only as directed cases. Every defined operation is swept exhaustively over all accumulator, carry and operand values, after the state has been loaded through LDM and CLC/STC. A seeded random mix then covers the remaining combinations.

// File: rtl/nac_pkg.sv
package nac_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_CLB = 5'h00, OP_CLC = 5'h01, OP_IAC = 5'h02, OP_CMC = 5'h03,
    OP_CMA = 5'h04, OP_RAL = 5'h05, OP_RAR = 5'h06, OP_TCC = 5'h07,
    OP_DAC = 5'h08, OP_TCS = 5'h09, OP_STC = 5'h0A, OP_DAA = 5'h0B,
    OP_KBP = 5'h0C,
    OP_ADD = 5'h10, OP_SUB = 5'h11, OP_LD  = 5'h12, OP_XCH = 5'h13,
    OP_LDM = 5'h14, OP_ORR = 5'h15, OP_ANR = 5'h16
  } op_e;
endpackage

// File: rtl/nac_arith.sv
module nac_arith
  import nac_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  op_e          op,
  input  logic [W-1:0] acc,
  input  logic         cy,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res_acc,
  output logic         res_cy,
  output logic         hit
);
  localparam logic [W:0] DEC_ADJ   = (W+1)'(6);
  localparam logic [W:0] DEC_LIMIT = (W+1)'(9);

  logic [W:0] ext_acc;
  logic [W:0] sum;

  assign ext_acc = {1'b0, acc};

  always_comb begin
    sum     = ext_acc;
    hit     = 1'b1;
    res_acc = acc;
    res_cy  = cy;
    unique case (op)
      OP_ADD: begin
        sum     = ext_acc + {1'b0, opnd} + {{W{1'b0}}, cy};
        res_acc = sum[W-1:0];
        res_cy  = sum[W];
      end
      OP_SUB: begin
        sum     = ext_acc + {1'b0, ~opnd} + {{W{1'b0}}, cy};
        res_acc = sum[W-1:0];
        res_cy  = sum[W];
      end
      OP_IAC: begin
        sum     = ext_acc + (W+1)'(1);
        res_acc = sum[W-1:0];
        res_cy  = sum[W];
      end
      OP_DAC: begin
        sum     = ext_acc + {1'b0, {W{1'b1}}};
        res_acc = sum[W-1:0];
        res_cy  = sum[W];
      end
      OP_DAA: begin
        if (cy || (ext_acc > DEC_LIMIT)) sum = ext_acc + DEC_ADJ;
        res_acc = sum[W-1:0];
        res_cy  = cy | sum[W];
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/nac_logic.sv
module nac_logic
  import nac_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  op_e          op,
  input  logic [W-1:0] acc,
  input  logic         cy,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] imm,
  output logic [W-1:0] res_acc,
  output logic         res_cy,
  output logic         hit
);
  localparam logic [W-1:0] TCS_LO = W'(9);
  localparam logic [W-1:0] TCS_HI = W'(10);

  logic [W-1:0] kbp_code;

  // one-hot to position+1, zero stays zero, several bits give all ones
  always_comb begin
    kbp_code = '0;
    if ($countones(acc) > 1) begin
      kbp_code = '1;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (acc[i]) kbp_code = W'(i + 1);
      end
    end
  end

  always_comb begin
    hit     = 1'b1;
    res_acc = acc;
    res_cy  = cy;
    unique case (op)
      OP_CLB: begin res_acc = '0; res_cy = 1'b0; end
      OP_CLC: res_cy = 1'b0;
      OP_STC: res_cy = 1'b1;
      OP_CMC: res_cy = ~cy;
      OP_CMA: res_acc = ~acc;
      OP_RAL: {res_cy, res_acc} = {acc, cy};
      OP_RAR: {res_acc, res_cy} = {cy, acc};
      OP_TCC: begin res_acc = {{(W-1){1'b0}}, cy}; res_cy = 1'b0; end
      OP_TCS: begin res_acc = cy ? TCS_HI : TCS_LO; res_cy = 1'b0; end
      OP_KBP: res_acc = kbp_code;
      OP_LD,
      OP_XCH: res_acc = opnd;
      OP_LDM: res_acc = imm;
      OP_ORR: res_acc = acc | opnd;
      OP_ANR: res_acc = acc & opnd;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/nibble_acc_alu.sv
module nibble_acc_alu
  import nac_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  input  logic [W-1:0]    operand,
  input  logic [W-1:0]    imm,
  output logic [W-1:0]    acc_q,
  output logic            cy_q,
  output logic            xch_we,
  output logic [W-1:0]    xch_data
);
  op_e          op;
  logic [W-1:0] ar_acc, lg_acc;
  logic         ar_cy, lg_cy, ar_hit, lg_hit;

  assign op = op_e'(op_code);

  nac_arith #(.W(W)) u_arith (
    .op(op), .acc(acc_q), .cy(cy_q), .opnd(operand),
    .res_acc(ar_acc), .res_cy(ar_cy), .hit(ar_hit)
  );

  nac_logic #(.W(W)) u_logic (
    .op(op), .acc(acc_q), .cy(cy_q), .opnd(operand), .imm(imm),
    .res_acc(lg_acc), .res_cy(lg_cy), .hit(lg_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      cy_q     <= 1'b0;
      xch_we   <= 1'b0;
      xch_data <= '0;
    end else begin
      xch_we <= op_valid && (op == OP_XCH);
      if (op_valid && (op == OP_XCH)) xch_data <= acc_q;
      if (op_valid && ar_hit) begin
        acc_q <= ar_acc;
        cy_q  <= ar_cy;
      end else if (op_valid && lg_hit) begin
        acc_q <= lg_acc;
        cy_q  <= lg_cy;
      end
    end
  end

  // R2
  decode_split_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ar_hit, lg_hit}));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(acc_q) && $stable(cy_q)));
  // R11
  keep_cy_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && (op inside {OP_LD, OP_LDM, OP_ORR, OP_ANR, OP_XCH, OP_KBP})
    |=> cy_q == $past(cy_q));
  // R8
  tcx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && (op inside {OP_TCC, OP_TCS}) |=> !cy_q);
  // R9
  daa_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && (op == OP_DAA) && cy_q |=> cy_q);
  // R10
  kbp_err_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && (op == OP_KBP) && ($countones(acc_q) > 1) |=> acc_q == '1);
  // R12
  xch_wb_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && (op == OP_XCH) |=> xch_we && (xch_data == $past(acc_q)));
endmodule

// File: tb/nibble_acc_alu_bench.sv
`timescale 1ns/1ps
module nibble_acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [3:0] operand = '0;
  logic [3:0] imm = '0;
  logic [3:0] acc_q;
  logic       cy_q;
  logic       xch_we;
  logic [3:0] xch_data;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_acc;
  logic       m_cy;

  always #2 clk = ~clk;

  nibble_acc_alu u_nibble_acc_alu (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .imm(imm), .acc_q(acc_q), .cy_q(cy_q),
    .xch_we(xch_we), .xch_data(xch_data)
  );

  localparam int NOPS = 20;
  localparam logic [4:0] OPS [NOPS] = '{
    5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09,
    5'h0A, 5'h0B, 5'h0C, 5'h10, 5'h11, 5'h12, 5'h13, 5'h14, 5'h15, 5'h16};

  function automatic string req_of(logic [4:0] op);
    case (op)
      5'h10: return "R3";
      5'h11: return "R4";
      5'h02, 5'h08: return "R5";
      5'h00, 5'h01, 5'h03, 5'h04, 5'h0A: return "R6";
      5'h05, 5'h06: return "R7";
      5'h07, 5'h09: return "R8";
      5'h0B: return "R9";
      5'h0C: return "R10";
      5'h12, 5'h14, 5'h15, 5'h16: return "R11";
      5'h13: return "R12";
      default: return "R2";
    endcase
  endfunction

  // returns {cy, acc}
  function automatic logic [4:0] ref_model(logic [4:0] op, logic [3:0] a,
                                           logic c, logic [3:0] r, logic [3:0] im);
    int s;
    logic [3:0] na = a;
    logic       nc = c;
    case (op)
      5'h10: begin s = a + r + c; na = 4'(s % 16); nc = s > 15; end
      5'h11: begin s = a + (15 - r) + c; na = 4'(s % 16); nc = s > 15; end
      5'h02: begin s = a + 1; na = 4'(s % 16); nc = s > 15; end
      5'h08: begin s = a + 15; na = 4'(s % 16); nc = s > 15; end
      5'h00: begin na = 0; nc = 0; end
      5'h01: nc = 0;
      5'h0A: nc = 1;
      5'h03: nc = !c;
      5'h04: na = 4'(15 - a);
      5'h05: begin na = {a[2:0], c}; nc = a[3]; end
      5'h06: begin na = {c, a[3:1]}; nc = a[0]; end
      5'h07: begin na = c ? 4'd1 : 4'd0; nc = 0; end
      5'h09: begin na = c ? 4'd10 : 4'd9; nc = 0; end
      5'h0B: if (c || a > 9) begin
               s = a + 6; na = 4'(s % 16); nc = c || (s > 15);
             end
      5'h0C: case (a)
               4'd0: na = 0; 4'd1: na = 1; 4'd2: na = 2;
               4'd4: na = 3; 4'd8: na = 4; default: na = 15;
             endcase
      5'h12, 5'h13: na = r;
      5'h14: na = im;
      5'h15: na = a | r;
      5'h16: na = a & r;
      default: ;
    endcase
    return {nc, na};
  endfunction

  task automatic issue(logic v, logic [4:0] op, logic [3:0] r, logic [3:0] im);
    @(negedge clk);
    op_valid = v; op_code = op; operand = r; imm = im;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic check_state(string rq, logic [4:0] op, logic [3:0] ea, logic ec,
                             logic ewe, logic [3:0] ed);
    checks++;
    if (acc_q !== ea || cy_q !== ec || xch_we !== ewe || (ewe && xch_data !== ed)) begin
      errors++;
      $display("FAIL %s op=%h actual acc=%h cy=%b we=%b xd=%h expected acc=%h cy=%b we=%b xd=%h",
               rq, op, acc_q, cy_q, xch_we, xch_data, ea, ec, ewe, ed);
    end
  endtask

  // load state, run op, compare against model
  task automatic run_one(logic v, logic [4:0] op, logic [3:0] a, logic c,
                         logic [3:0] r, logic [3:0] im);
    logic [4:0] e;
    issue(1'b1, 5'h14, 4'h0, a);
    issue(1'b1, c ? 5'h0A : 5'h01, 4'h0, 4'h0);
    issue(v, op, r, im);
    e = v ? ref_model(op, a, c, r, im) : {c, a};
    check_state(v ? req_of(op) : "R2", op, e[3:0], e[4],
                v && op == 5'h13, a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state after dirtying the registers
    rst = 1'b0;
    issue(1'b1, 5'h14, 4'h0, 4'h7);
    issue(1'b1, 5'h13, 4'h3, 4'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check_state("R1", 5'h00, 4'h0, 1'b0, 1'b0, 4'h0);

    // exhaustive sweep of every defined op
    for (int o = 0; o < NOPS; o++)
      for (int a = 0; a < 16; a++)
        for (int c = 0; c < 2; c++)
          for (int r = 0; r < 16; r++)
            run_one(1'b1, OPS[o], 4'(a), c[0], 4'(r), 4'(r ^ 5));

    // R2: undefined codes and a low strobe leave state untouched
    for (int u = 13; u < 16; u++) run_one(1'b1, 5'(u), 4'h9, 1'b1, 4'h3, 4'h2);
    for (int u = 23; u < 32; u++) run_one(1'b1, 5'(u), 4'h5, 1'b0, 4'hA, 4'h1);
    for (int o = 0; o < NOPS; o++) run_one(1'b0, OPS[o], 4'hC, 1'b1, 4'h6, 4'h4);

    // directed corners
    run_one(1'b1, 5'h0B, 4'h9, 1'b0, 4'h0, 4'h0); // R9 no adjust at 9
    run_one(1'b1, 5'h0B, 4'hA, 1'b0, 4'h0, 4'h0); // R9 adjust, carry out
    run_one(1'b1, 5'h0B, 4'h2, 1'b1, 4'h0, 4'h0); // R9 adjust, carry kept
    run_one(1'b1, 5'h0C, 4'hF, 1'b1, 4'h0, 4'h0); // R10 error code
    run_one(1'b1, 5'h08, 4'h0, 1'b1, 4'h0, 4'h0); // R5 borrow on zero
    run_one(1'b1, 5'h11, 4'h0, 1'b0, 4'hF, 4'h0); // R4 deepest borrow

    // seeded random mix, including back-to-back ops on live state
    m_acc = acc_q; m_cy = cy_q;
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] op;
      logic [3:0] r, im, old;
      logic [4:0] e;
      logic v;
      op  = OPS[$urandom_range(NOPS - 1)];
      r   = 4'($urandom);
      im  = 4'($urandom);
      v   = ($urandom_range(7) != 0);
      old = m_acc;
      issue(v, op, r, im);
      e = v ? ref_model(op, m_acc, m_cy, r, im) : {m_cy, m_acc};
      check_state(v ? req_of(op) : "R2", op, e[3:0], e[4], v && op == 5'h13, old);
      m_acc = e[3:0]; m_cy = e[4];
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule